// File: doc/BRIEF.md
# Prioritising Interrupt Controller

This block gathers interrupt requests from a parameterised set of peripheral sources and drives one interrupt line toward a single processor. Software sets up each source through a small word-addressed register port with separate read and write strobes. For each source it sets a priority, a trigger style and an enable. It also sets one threshold for the processor. Source inputs are asynchronous and pass through a two-flop synchroniser before the block uses them.

When the processor takes the interrupt, it reads the claim/complete register. That read returns the number of the most urgent source that may interrupt, and it removes that source from contention. When the handler has finished, the processor writes the same number back to the same register, and the source can raise a request again. A separate software-interrupt bit drives a second output line.

Source numbers start at 1. The number 0 means "no source". Byte addresses are used, and the two low address bits are ignored.

Top module: `irq_hub`

## Requirements
- R1: After reset, irq_o and swi_o are 0. Every priority, enable, trigger-type, threshold and software-interrupt register reads 0, and a claim read returns 0.
- R2: A source can interrupt only when its enable bit is 1 and its priority is strictly greater than the threshold at 0x280 (values 0 to 3). A source with priority 0 therefore never interrupts.
- R3: Among the pending sources that can interrupt, the claim read returns the one with the highest priority. When priorities are equal, the lowest source number wins.
- R4: A read of 0x284 returns the winning source number in rdata_o one cycle after the read strobe, and it clears that source's pending bit. When no source can interrupt, the read returns 0 and changes nothing.
- R5: A claimed source cannot become pending again until a write to 0x284 carries its number. A write with any other number, including one for a source that is not claimed, has no effect.
- R6: With trigger bit 0 (level), the pending bit follows the synchronised input while the source is not claimed. The pending bit appears three clock edges after the input changes.
- R7: With trigger bit 1 (edge), a rising edge on the synchronised input sets the pending bit. The bit stays set after the input falls, until a claim clears it.
- R8: Source n has its enable, trigger and pending bits in word (n-1)/32, bit (n-1)%32. Pending words are at 0x100+4k, trigger words at 0x180+4k and enable words at 0x200+4k. The priority of source n is in bits [1:0] of 0x000+(n-1)*4.
- R9: Writes to the pending words, and writes to any address outside the map, change no state. A read of an address outside the map returns 0.
- R10: Bit 0 of the register at 0x288 drives swi_o, starting one cycle after the write.
- R11: If a completion write and a new rising edge of the same edge-triggered source land in the same cycle, the edge is kept and the source becomes pending.
- R12: irq_o is 1 exactly when at least one pending source can interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | NSRC | Asynchronous interrupt requests; bit n-1 is source n |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request to the processor |
| swi_o | output | 1 | Software interrupt to the processor |

## Verification
The completion of a claimed edge-triggered source can fall in the same cycle as a new rising edge on that source's input. The bench raises the input, then counts the synchroniser stages so that the completion write is sampled on the very edge where the rising edge is detected. It expects irq_o to rise on the next cycle and the next claim read to return the same source number. It also claims a source while that source's input is pulsing again, and it expects the pulse to be dropped.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int ADDR_W = 10;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_TRIG,
    RG_EN,
    RG_THR,
    RG_CLAIM,
    RG_SWI
  } region_e;

  // Map a byte address to a register region.
  function automatic region_e region_of(logic [ADDR_W-1:0] a);
    region_e r;
    case (a[9:7])
      3'b000, 3'b001: r = RG_PRIO;
      3'b010:         r = RG_PEND;
      3'b011:         r = RG_TRIG;
      3'b100:         r = RG_EN;
      3'b101: begin
        case (a[6:2])
          5'd0:    r = RG_THR;
          5'd1:    r = RG_CLAIM;
          5'd2:    r = RG_SWI;
          default: r = RG_NONE;
        endcase
      end
      default:        r = RG_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_hub_insync.sv
module irq_hub_insync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/irq_hub_gate.sv
module irq_hub_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_mode_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);

  logic prev_q, pend_q, busy_q;
  logic prev_n, pend_n, busy_n;
  logic rise;

  assign rise = req_i & ~prev_q;

  always_comb begin
    prev_n = req_i;
    busy_n = (busy_q | claim_i) & ~done_i;
    if (edge_mode_i) begin
      pend_n = ~claim_i & (pend_q | (rise & ~busy_n));
    end else begin
      pend_n = req_i & ~busy_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= prev_n;
      pend_q <= pend_n;
      busy_q <= busy_n;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

  // R5: a source under service never shows as pending
  a_r5_idle_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && busy_q));

  // R4/R5: a claim clears pending and marks the source busy
  a_r5_claim_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && !done_i) |=> (busy_q && !pend_q));

  // R7: edge-latched pending holds until claimed
  a_r7_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && pend_q && !claim_i) |=> pend_q);

endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick #(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 2,
  parameter int IDW    = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NSRC-1:0]              pend_i,
  input  logic [NSRC-1:0]              en_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic                         valid_o,
  output logic [IDW-1:0]               id_o
);

  logic [NSRC-1:0]   elig;
  logic [PRIO_W-1:0] best_p;
  logic [IDW-1:0]    best_id;

  // Ascending scan with strict compare: equal priority keeps the lower ID.
  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      elig[i] = pend_i[i] & en_i[i] & (prio_i[i] > thr_i);
      if (elig[i] && (prio_i[i] > best_p)) begin
        best_p  = prio_i[i];
        best_id = IDW'(i + 1);
      end
    end
  end

  assign valid_o = |elig;
  assign id_o    = best_id;

  // R2/R3: the reported winner is itself eligible
  a_r2_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (id_o != '0) && pend_i[id_o - 1'b1] && en_i[id_o - 1'b1]
                && (prio_i[id_o - 1'b1] > thr_i));

  // R12: no winner means the ID reads zero
  a_r12_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (id_o == '0));

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 2,
  parameter int IDW    = 6,
  parameter int NWORDS = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  logic [NSRC-1:0]              pend_i,
  input  logic                         best_valid_i,
  input  logic [IDW-1:0]               best_id_i,
  output logic [NSRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NSRC-1:0]              en_o,
  output logic [NSRC-1:0]              trig_o,
  output logic [PRIO_W-1:0]            thr_o,
  output logic                         swi_o,
  output logic [NSRC-1:0]              claim_o,
  output logic [NSRC-1:0]              done_o,
  output logic [WORD_W-1:0]            rdata_o
);

  localparam int PADW = NWORDS * WORD_W;

  region_e  rg;
  logic [5:0] pidx;
  logic [4:0] widx;
  logic       unused_lowbits;

  logic [NSRC-1:0][PRIO_W-1:0] prio_q, prio_n;
  logic [NSRC-1:0]             en_q, en_n;
  logic [NSRC-1:0]             trig_q, trig_n;
  logic [PRIO_W-1:0]           thr_q, thr_n;
  logic                        swi_q, swi_n;
  logic [WORD_W-1:0]           rdata_q, rdata_n;
  logic                        cfg_we;
  logic [PADW-1:0]             pend_pad, en_pad, trig_pad;
  logic                        claim_rd, done_wr;

  assign rg             = region_of(addr_i);
  assign pidx           = addr_i[7:2];
  assign widx           = addr_i[6:2];
  assign unused_lowbits = ^addr_i[1:0];
  assign cfg_we         = wr_en_i;

  // Configuration next state
  always_comb begin
    prio_n = prio_q;
    en_n   = en_q;
    trig_n = trig_q;
    thr_n  = thr_q;
    swi_n  = swi_q;
    case (rg)
      RG_PRIO: begin
        for (int i = 0; i < NSRC; i++) begin
          if (pidx == 6'(i)) prio_n[i] = wdata_i[PRIO_W-1:0];
        end
      end
      RG_TRIG: begin
        for (int i = 0; i < NSRC; i++) begin
          if (widx == 5'(i / WORD_W)) trig_n[i] = wdata_i[i % WORD_W];
        end
      end
      RG_EN: begin
        for (int i = 0; i < NSRC; i++) begin
          if (widx == 5'(i / WORD_W)) en_n[i] = wdata_i[i % WORD_W];
        end
      end
      RG_THR:  thr_n = wdata_i[PRIO_W-1:0];
      RG_SWI:  swi_n = wdata_i[0];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      trig_q <= '0;
      thr_q  <= '0;
      swi_q  <= 1'b0;
    end else if (cfg_we) begin
      prio_q <= prio_n;
      en_q   <= en_n;
      trig_q <= trig_n;
      thr_q  <= thr_n;
      swi_q  <= swi_n;
    end
  end

  // Read data next state
  always_comb begin
    pend_pad              = '0;
    pend_pad[NSRC-1:0]    = pend_i;
    en_pad                = '0;
    en_pad[NSRC-1:0]      = en_q;
    trig_pad              = '0;
    trig_pad[NSRC-1:0]    = trig_q;
    rdata_n               = '0;
    case (rg)
      RG_PRIO: begin
        for (int i = 0; i < NSRC; i++) begin
          if (pidx == 6'(i)) rdata_n = WORD_W'(prio_q[i]);
        end
      end
      RG_PEND: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (widx == 5'(w)) rdata_n = pend_pad[w*WORD_W +: WORD_W];
        end
      end
      RG_TRIG: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (widx == 5'(w)) rdata_n = trig_pad[w*WORD_W +: WORD_W];
        end
      end
      RG_EN: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (widx == 5'(w)) rdata_n = en_pad[w*WORD_W +: WORD_W];
        end
      end
      RG_THR:   rdata_n = WORD_W'(thr_q);
      RG_CLAIM: rdata_n = WORD_W'(best_id_i);
      RG_SWI:   rdata_n = WORD_W'(swi_q);
      default:  rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rdata_n;
    end
  end

  // Claim and completion strobes, one-hot per source
  assign claim_rd = rd_en_i && (rg == RG_CLAIM) && best_valid_i;
  assign done_wr  = wr_en_i && (rg == RG_CLAIM);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      claim_o[i] = claim_rd && (best_id_i == IDW'(i + 1));
      done_o[i]  = done_wr && (wdata_i == WORD_W'(i + 1));
    end
  end

  assign prio_o  = prio_q;
  assign en_o    = en_q;
  assign trig_o  = trig_q;
  assign thr_o   = thr_q;
  assign swi_o   = swi_q;
  assign rdata_o = rdata_q;

  // R4: a claim read with nothing eligible returns zero
  a_r4_empty_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (rg == RG_CLAIM) && !best_valid_i) |=> (rdata_o == '0));

  // R10: software interrupt output follows the written bit
  a_r10_swi_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (rg == RG_SWI)) |=> (swi_o == $past(wdata_i[0])));

  // R9: writes outside the map leave configuration unchanged
  a_r9_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ((rg == RG_NONE) || (rg == RG_PEND))) |=>
      ($stable(en_q) && $stable(trig_q) && $stable(thr_q) && $stable(swi_q)));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [9:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              swi_o
);

  localparam int IDW    = $clog2(NSRC + 1);
  localparam int NWORDS = (NSRC + WORD_W - 1) / WORD_W;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NSRC-1:0]             req_sync;
  logic [NSRC-1:0]             pend, busy, claim, done;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [NSRC-1:0]             en, trig;
  logic [PRIO_W-1:0]           thr;
  logic                        best_valid;
  logic [IDW-1:0]              best_id;

  irq_hub_insync #(.W(NSRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (src_i),
    .sync_o  (req_sync)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    irq_hub_gate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .req_i       (req_sync[g]),
      .edge_mode_i (trig[g]),
      .claim_i     (claim[g]),
      .done_i      (done[g]),
      .pend_o      (pend[g]),
      .busy_o      (busy[g])
    );
  end

  irq_hub_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .pend_i  (pend),
    .en_i    (en),
    .prio_i  (prio),
    .thr_i   (thr),
    .valid_o (best_valid),
    .id_o    (best_id)
  );

  irq_hub_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW), .NWORDS(NWORDS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .rd_en_i      (rd_en_i),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .pend_i       (pend),
    .best_valid_i (best_valid),
    .best_id_i    (best_id),
    .prio_o       (prio),
    .en_o         (en),
    .trig_o       (trig),
    .thr_o        (thr),
    .swi_o        (swi_o),
    .claim_o      (claim),
    .done_o       (done),
    .rdata_o      (rdata_o)
  );

  assign irq_o = best_valid;

  // R4: at most one source is claimed per read, and only a pending one
  a_r4_claim_onehot: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(claim) && ((claim & ~pend) == '0));

  // R5: a claimed source stays out of contention until completed
  a_r5_busy_held: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((busy & ~done) != '0) |=> ((busy & $past(busy & ~done)) == $past(busy & ~done)));

endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

  localparam int NSRC = 40;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src;
  logic            rd_en, wr_en;
  logic [9:0]      addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic            irq, swi;

  int total = 0;
  int bad   = 0;
  bit done_flag = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen_q = 1'b0;

  always #4 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .PRIO_W(2)) u_irq_hub (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq),
    .swi_o   (swi)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read value once the read result appears
  always @(posedge clk) rd_seen_q <= rd_en;
  always @(negedge clk) begin
    if (rd_seen_q && exp_q.size() > 0) begin
      chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  // Driver tasks: called at a falling edge, return at the next falling edge
  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_rd(logic [9:0] a, logic [31:0] exp, string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src = '0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 swi_o", 32'(swi), 0);
    bus_rd(10'h284, 0, "R1 claim empty");
    bus_rd(10'h280, 0, "R1 threshold");
    bus_rd(10'h000, 0, "R1 prio id1");
    bus_rd(10'h09C, 0, "R1 prio id40");
    bus_rd(10'h200, 0, "R1 enable w0");
    bus_rd(10'h184, 0, "R1 trigger w1");

    // R10: software interrupt
    bus_wr(10'h288, 1);
    chk("R10 swi set", 32'(swi), 1);
    bus_rd(10'h288, 1, "R10 swi readback");
    bus_wr(10'h288, 0);
    chk("R10 swi clear", 32'(swi), 0);

    // R8/R6: source 33 = word 1 bit 0, level mode
    bus_wr(10'h080, 2);
    bus_wr(10'h204, 1);
    bus_rd(10'h080, 2, "R8 prio id33 readback");
    bus_rd(10'h204, 1, "R8 enable w1 readback");
    src[32] = 1'b1;
    idle(3);
    chk("R6 level raises irq", 32'(irq), 1);
    bus_rd(10'h104, 1, "R8 pending w1 bit0");
    bus_rd(10'h284, 33, "R4 claim id33");
    chk("R5 irq after claim", 32'(irq), 0);
    bus_rd(10'h104, 0, "R4 pending cleared");
    bus_wr(10'h284, 5);
    idle(2);
    chk("R5 mismatched completion ignored", 32'(irq), 0);
    bus_wr(10'h284, 33);
    chk("R6 level repends after completion", 32'(irq), 1);
    src[32] = 1'b0;
    idle(3);
    chk("R6 level follows input low", 32'(irq), 0);

    // R2: threshold and priority zero
    src[32] = 1'b1;
    idle(3);
    bus_wr(10'h280, 2);
    chk("R2 prio equal to threshold", 32'(irq), 0);
    bus_wr(10'h280, 1);
    chk("R2 prio above threshold", 32'(irq), 1);
    bus_wr(10'h080, 0);
    bus_wr(10'h280, 0);
    chk("R2 prio zero never", 32'(irq), 0);
    bus_wr(10'h080, 2);
    chk("R12 irq with eligible source", 32'(irq), 1);
    bus_wr(10'h204, 0);
    chk("R2 disabled source", 32'(irq), 0);
    src[32] = 1'b0;
    idle(3);

    // R3: ordering by priority then lowest ID
    bus_wr(10'h004, 1);
    bus_wr(10'h008, 3);
    bus_wr(10'h010, 3);
    bus_wr(10'h200, 32'h16);
    src[1] = 1'b1; src[2] = 1'b1; src[4] = 1'b1;
    idle(3);
    bus_rd(10'h284, 3, "R3 tie lowest id");
    bus_rd(10'h284, 5, "R3 second of tie");
    bus_rd(10'h284, 2, "R3 lower priority last");
    bus_rd(10'h284, 0, "R4 empty claim");
    chk("R12 irq idle", 32'(irq), 0);
    src[1] = 1'b0; src[2] = 1'b0; src[4] = 1'b0;
    idle(3);
    bus_wr(10'h284, 3);
    bus_wr(10'h284, 5);
    bus_wr(10'h284, 2);
    chk("R6 completed with input low", 32'(irq), 0);

    // R7: edge mode on source 7 (word 0 bit 6)
    bus_wr(10'h018, 1);
    bus_wr(10'h180, 32'h40);
    bus_wr(10'h200, 32'h40);
    bus_rd(10'h180, 32'h40, "R8 trigger w0 readback");
    src[6] = 1'b1;
    @(negedge clk);
    src[6] = 1'b0;
    idle(4);
    chk("R7 edge latched after pulse", 32'(irq), 1);
    bus_rd(10'h284, 7, "R7 claim edge source");
    src[6] = 1'b1;
    @(negedge clk);
    src[6] = 1'b0;
    idle(4);
    chk("R5 edge during service dropped", 32'(irq), 0);
    bus_rd(10'h100, 0, "R5 pending word0 in service");
    bus_wr(10'h284, 7);
    idle(1);
    chk("R5 dropped edge stays lost", 32'(irq), 0);

    // R11: completion and new edge in the same cycle
    src[6] = 1'b1;
    @(negedge clk);
    src[6] = 1'b0;
    idle(4);
    bus_rd(10'h284, 7, "R11 setup claim");
    idle(3);
    src[6] = 1'b1;
    idle(2);
    bus_wr(10'h284, 7);
    chk("R11 edge kept at completion", 32'(irq), 1);
    bus_rd(10'h284, 7, "R11 claim after collision");
    src[6] = 1'b0;
    bus_wr(10'h284, 7);
    idle(3);
    chk("R11 clean after completion", 32'(irq), 0);

    // R9: read-only pending and unmapped addresses
    bus_wr(10'h100, 32'hFFFF_FFFF);
    idle(1);
    bus_rd(10'h100, 0, "R9 pending write ignored");
    chk("R9 irq after pending write", 32'(irq), 0);
    bus_wr(10'h300, 32'hFFFF_FFFF);
    bus_wr(10'h28C, 32'hFFFF_FFFF);
    bus_rd(10'h200, 32'h40, "R9 enable unchanged");
    bus_rd(10'h180, 32'h40, "R9 trigger unchanged");
    bus_rd(10'h280, 0, "R9 threshold unchanged");
    bus_rd(10'h288, 0, "R9 swi unchanged");
    bus_rd(10'h300, 0, "R9 unmapped reads zero");
    chk("R9 swi_o", 32'(swi), 0);

    idle(3);
    finish_run();
  end

endmodule